// File: doc/BRIEF.md
# Buffered PWM Reload Control Unit

This unit keeps the control settings that a multi-channel PWM generator reads: a two-bit reload spacing code, one correction-select bit for each of three output pairs, and a two-bit counter prescaler. Software writes all the settings in one 8-bit register. The writes go to a shadow copy. Each setting moves to its active copy on its own event. The spacing code moves when the current reload period ends. The correction bits move at every PWM cycle start, and only for pairs set to software correction. The prescaler moves only at a reload boundary while the load-okay flag is set.

The PWM counter gives one `cyc_start` pulse per PWM period. The unit counts these pulses and raises `reload_stb` for one clock when the active reload period ends. The period is 1, 2, 4 or 8 PWM cycles. A read always returns the shadow copy, so software can check what it wrote before that value takes effect.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, `rd_data`, `ldfq_act`, `corr_act`, `prsc_act`, `ldok_pend` and `reload_stb` are all 0.
- R2: `rd_data` returns the shadow copy. Bits 7:6 hold the spacing code and bit 5 always reads 0. Bits 4, 3 and 2 hold the correction bits of pairs 1, 2 and 3, which map to `corr_act[0]`, `corr_act[1]` and `corr_act[2]`. Bits 1:0 hold the prescaler. The active outputs do not change because of a write.
- R3: With active spacing code 00, 01, 10 or 11, `reload_stb` is high for one clock after every 1st, 2nd, 4th or 8th `cyc_start` pulse. It is high in the clock after the `cyc_start` pulse that completes the period.
- R4: `ldfq_act` takes the shadow spacing code only at a reload strobe, whatever the state of load-okay. The new spacing is counted from that strobe.
- R5: `prsc_act` takes the shadow prescaler only at a reload strobe that happens while `ldok_pend` is 1. Otherwise it holds.
- R6: A load-okay write with `ldok_wdata`=1 sets `ldok_pend`, and one with `ldok_wdata`=0 has no effect. The flag clears at the reload strobe that uses it, unless a set write happens in the same clock.
- R7: At every `cyc_start`, `corr_act[i]` takes the shadow bit of its pair only if `sw_corr[i]` is 1. Pairs with `sw_corr[i]`=0 hold their value. A value of 0 selects the pair's first value register and 1 selects the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Read-back of the shadow copy |
| ldok_wr | input | 1 | Write strobe for the load-okay flag |
| ldok_wdata | input | 1 | Load-okay write value; only 1 acts |
| ldok_pend | output | 1 | Load-okay flag |
| cyc_start | input | 1 | One-clock pulse at each PWM cycle start |
| sw_corr | input | 3 | Per-pair software-correction enable |
| ldfq_act | output | 2 | Active reload spacing code |
| corr_act | output | 3 | Active correction selects, index 0 = pair 1 |
| prsc_act | output | 2 | Active prescaler |
| reload_stb | output | 1 | Reload strobe |

## Verification
If the cycle counter holds a wrong value, the strobe comes at the wrong place within the first reload period that follows, up to eight `cyc_start` pulses later. This is why strobe spacing is measured over two full periods for each code. A stuck or lost load-okay flag shows at the next reload boundary: either the prescaler changes when nothing requested it, or a requested change never happens. A wrong pair-bit mapping shows on `corr_act` at the first cycle start after a write with asymmetric pair bits.

// File: rtl/pwm_rl_pkg.sv
package pwm_rl_pkg;
    localparam int DATA_W    = 8;
    localparam int LDFQ_W    = 2;
    localparam int PRSC_W    = 2;
    localparam int NUM_PAIRS = 3;
    localparam int LDFQ_LSB  = DATA_W - LDFQ_W;      // spacing code in the top bits
    localparam int CORR_MSB  = LDFQ_LSB - 2;         // one reserved bit below the spacing code
    localparam int PRSC_LSB  = 0;
    localparam int CNT_W     = (1 << LDFQ_W) - 1;    // enough for the longest period

    typedef struct packed {
        logic [LDFQ_W-1:0]    ldfq;
        logic [NUM_PAIRS-1:0] corr;
        logic [PRSC_W-1:0]    prsc;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [DATA_W-1:0] d);
        ctl_t c;
        c.ldfq = d[LDFQ_LSB +: LDFQ_W];
        for (int i = 0; i < NUM_PAIRS; i++) c.corr[i] = d[CORR_MSB - i];
        c.prsc = d[PRSC_LSB +: PRSC_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[LDFQ_LSB +: LDFQ_W] = c.ldfq;
        for (int i = 0; i < NUM_PAIRS; i++) d[CORR_MSB - i] = c.corr[i];
        d[PRSC_LSB +: PRSC_W] = c.prsc;
        return d;
    endfunction
endpackage

// File: rtl/pwm_rl_regbuf.sv
module pwm_rl_regbuf
    import pwm_rl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ldok_wr,
    input  logic              ldok_wdata,
    input  logic              ldok_take,
    output ctl_t              shadow_o,
    output logic [DATA_W-1:0] rd_data,
    output logic              ldok_o
);
    typedef struct packed {
        ctl_t ctl;
        logic ldok;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ctl = unpack_ctl(wr_data);
        if (ldok_wr && ldok_wdata) s_d.ldok = 1'b1;   // a set in the same clock beats the clear
        else if (ldok_take)        s_d.ldok = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shadow_o = s_q.ctl;
    assign rd_data  = pack_ctl(s_q.ctl);
    assign ldok_o   = s_q.ldok;

    AST_RD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data == ($past(wr_data) & pack_ctl(ctl_t'('1)))); // R2
endmodule

// File: rtl/pwm_rl_cycle_cnt.sv
module pwm_rl_cycle_cnt
    import pwm_rl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [LDFQ_W-1:0] ldfq_next,
    output logic [LDFQ_W-1:0] ldfq_act,
    output logic              wrap_now,
    output logic              reload_stb
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LDFQ_W-1:0] ldfq;
        logic              stb;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = CNT_W'((32'd1 << s_q.ldfq) - 32'd1);
        wrap_now = cyc_start && (s_q.cnt == last);
        s_d      = s_q;
        s_d.stb  = wrap_now;
        if (cyc_start) begin
            if (wrap_now) begin
                s_d.cnt  = '0;
                s_d.ldfq = ldfq_next;   // spacing swaps at the period end, load-okay not involved
            end else begin
                s_d.cnt  = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ldfq_act   = s_q.ldfq;
    assign reload_stb = s_q.stb;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= last); // R3
    AST_STB_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |-> $past(cyc_start)); // R3
    AST_LDFQ_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ldfq_act) |-> reload_stb); // R4
endmodule

// File: rtl/pwm_rl_corr_latch.sv
module pwm_rl_corr_latch
    import pwm_rl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_start,
    input  logic [NUM_PAIRS-1:0] sw_corr,
    input  logic [NUM_PAIRS-1:0] corr_shadow,
    output logic [NUM_PAIRS-1:0] corr_act
);
    typedef struct packed {
        logic [NUM_PAIRS-1:0] sel;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_PAIRS; i++)
            if (cyc_start && sw_corr[i]) s_d.sel[i] = corr_shadow[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign corr_act = s_q.sel;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair_chk
        AST_PAIR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(corr_act[g]) |-> $past(cyc_start && sw_corr[g])); // R7
    end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_rl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 ldok_wr,
    input  logic                 ldok_wdata,
    output logic                 ldok_pend,
    input  logic                 cyc_start,
    input  logic [NUM_PAIRS-1:0] sw_corr,
    output logic [LDFQ_W-1:0]    ldfq_act,
    output logic [NUM_PAIRS-1:0] corr_act,
    output logic [PRSC_W-1:0]    prsc_act,
    output logic                 reload_stb
);
    ctl_t shadow;
    logic wrap_now;
    logic ldok_take;

    typedef struct packed {
        logic [PRSC_W-1:0] prsc;
    } st_t;

    st_t s_d, s_q;

    pwm_rl_regbuf u_regbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ldok_wr(ldok_wr), .ldok_wdata(ldok_wdata), .ldok_take(ldok_take),
        .shadow_o(shadow), .rd_data(rd_data), .ldok_o(ldok_pend)
    );

    pwm_rl_cycle_cnt u_cnt (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ldfq_next(shadow.ldfq),
        .ldfq_act(ldfq_act), .wrap_now(wrap_now), .reload_stb(reload_stb)
    );

    pwm_rl_corr_latch u_corr (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .sw_corr(sw_corr),
        .corr_shadow(shadow.corr), .corr_act(corr_act)
    );

    always_comb begin
        ldok_take = wrap_now && ldok_pend;
        s_d       = s_q;
        if (ldok_take) s_d.prsc = shadow.prsc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prsc_act = s_q.prsc;

    AST_PRSC_NEEDS_LDOK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prsc_act) |-> (reload_stb && $past(ldok_pend))); // R5
    AST_LDOK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_stb && $past(ldok_pend) && !$past(ldok_wr && ldok_wdata)) |-> !ldok_pend); // R6
    AST_LDOK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ldok_wr && ldok_wdata) |-> ldok_pend); // R6
endmodule

// File: tb/pwm_reload_ctrl_test.sv
module pwm_reload_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ldok_wr = 1'b0;
    logic       ldok_wdata = 1'b0;
    logic       ldok_pend;
    logic       cyc_start = 1'b0;
    logic [2:0] sw_corr = 3'b111;
    logic [1:0] ldfq_act;
    logic [2:0] corr_act;
    logic [1:0] prsc_act;
    logic       reload_stb;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_reload_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ldok_wr(ldok_wr), .ldok_wdata(ldok_wdata), .ldok_pend(ldok_pend),
        .cyc_start(cyc_start), .sw_corr(sw_corr), .ldfq_act(ldfq_act),
        .corr_act(corr_act), .prsc_act(prsc_act), .reload_stb(reload_stb)
    );

    typedef struct packed {
        logic [7:0] data;
        logic [3:0] period;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{data: 8'hC1, period: 4'd8},
        '{data: 8'h02, period: 4'd1},
        '{data: 8'h83, period: 4'd4},
        '{data: 8'h43, period: 4'd2}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic write_ldok(input logic v);
        @(negedge clk) begin ldok_wr = 1'b1; ldok_wdata = v; end
        @(negedge clk) ldok_wr = 1'b0;
    endtask

    task automatic pulse(output logic stb);
        @(negedge clk) cyc_start = 1'b1;
        @(negedge clk) cyc_start = 1'b0;
        stb = reload_stb;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic stb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "ldfq_act", ldfq_act, 0);
        chk("R1", "corr_act", corr_act, 0);
        chk("R1", "prsc_act", prsc_act, 0);
        chk("R1", "ldok_pend", ldok_pend, 0);
        chk("R1", "reload_stb", reload_stb, 0);
        @(negedge clk) rst_n = 1'b1;

        // R3, R4: strobe spacing per code; R5: prescaler holds without load-okay; R2 read-back
        for (int k = 0; k < 4; k++) begin
            int seen;
            write_reg(VEC[k].data);
            chk("R2", "rd_data after write", rd_data, VEC[k].data & 8'hDF);
            seen = 0;
            for (int n = 0; n < 9 && seen == 0; n++) begin
                pulse(stb);
                if (stb) seen = 1;
            end
            chk("R4", "strobe seen before switch", seen, 1);
            chk("R4", "ldfq_act after boundary", ldfq_act, VEC[k].data[7:6]);
            for (int j = 1; j <= 2 * VEC[k].period; j++) begin
                pulse(stb);
                chk("R3", "reload_stb spacing", stb, (j % VEC[k].period) == 0);
            end
            chk("R5", "prsc_act without load-okay", prsc_act, 0);
        end

        // R6: set/ignore semantics of load-okay
        write_ldok(1'b0);
        chk("R6", "ldok after write 0", ldok_pend, 0);
        write_ldok(1'b1);
        chk("R6", "ldok after write 1", ldok_pend, 1);
        write_ldok(1'b0);
        chk("R6", "ldok after second write 0", ldok_pend, 1);

        // R5: prescaler waits for the boundary (period 2, counter at 0)
        pulse(stb);
        chk("R5", "prsc_act mid-period", prsc_act, 0);
        chk("R6", "ldok kept mid-period", ldok_pend, 1);
        pulse(stb);
        chk("R3", "strobe at boundary", stb, 1);
        chk("R5", "prsc_act at boundary", prsc_act, 3);
        chk("R6", "ldok consumed", ldok_pend, 0);

        write_reg(8'h41);
        pulse(stb);
        pulse(stb);
        chk("R5", "prsc_act held after boundary without ldok", prsc_act, 3);

        // R7: per-pair correction gating and bit mapping
        sw_corr = 3'b111;
        write_reg(8'h50);
        chk("R2", "rd_data pair1 set", rd_data, 8'h50);
        chk("R2", "corr_act unchanged by write", corr_act, 0);
        pulse(stb);
        chk("R7", "corr_act pair1 only", corr_act, 3'b001);
        sw_corr = 3'b010;
        write_reg(8'h4C);
        pulse(stb);
        chk("R7", "corr_act gated pairs", corr_act, 3'b011);

        // R2: reserved bit reads 0, actives untouched by write
        write_reg(8'hFF);
        chk("R2", "rd_data reserved bit", rd_data, 8'hDF);
        chk("R2", "ldfq_act untouched", ldfq_act, 1);
        chk("R2", "prsc_act untouched", prsc_act, 3);
        chk("R2", "corr_act untouched", corr_act, 3'b011);

        // R1: reset mid-run
        write_ldok(1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rd_data after reset", rd_data, 0);
        chk("R1", "ldfq_act after reset", ldfq_act, 0);
        chk("R1", "corr_act after reset", corr_act, 0);
        chk("R1", "prsc_act after reset", prsc_act, 0);
        chk("R1", "ldok_pend after reset", ldok_pend, 0);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule